// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This block decides where each of the two source operands of the instruction in the register-read stage should come from. It can use the register-file read port, the result the ALU stage is computing in the current cycle, or the value the memory/writeback stage is about to write. It takes these inputs:

- destination-match terms that compare the stage-2 and stage-3 destinations against each source specifier;
- a flag saying the stage-2 instruction produces its result in the ALU;
- a flag saying stage 3 writes the register file;
- a flag per source saying the specifier is register 31.

For each operand it outputs a 2-bit select, a "forwarded" flag for the stall detector, and the chosen 32-bit value.

The block is purely combinational and sits ahead of the ordinary operand-select muxes. The stall detector uses the forwarded flags to drop stalls that forwarding has already resolved. A load in stage 2 produces its value too late to forward. When a load in stage 2 matches a source, that operand is left on the register file and its flag is left low, so the detector still holds the pipe.

Top module: `opfwd_bypass_unit`

## Requirements
- R1: When a source's register-31 flag is set, its select is 00 (register file), its forwarded flag is 0, and its operand equals the register-file data, whatever the match terms are.
- R2: When a source matches the stage-2 destination and the stage-2 instruction produces an ALU result, its select is 01 and its operand equals the ALU-stage result.
- R3: When a source matches the stage-3 destination, stage 3 writes the register file, and there is no stage-2 match, its select is 10 and its operand equals the writeback value.
- R4: When a source matches both stages and stage 2 produces an ALU result, the stage-2 result wins (select 01).
- R5: When a source matches stage 2 but stage 2 does not produce an ALU result (a load), the select is 00 and the flag is 0, even if stage 3 also matches.
- R6: With no match, or with a stage-3 match while stage 3 does not write the register file, the select is 00 and the operand is the register-file data.
- R7: Each forwarded flag is 1 exactly when its select is non-zero. The select value 11 never appears.
- R8: The two operands are decided independently: the inputs of one source never change the other's select, flag or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hit_alu | input | 2 | Stage-2 destination matches source (bit 0 = A, bit 1 = B) |
| hit_wb | input | 2 | Stage-3 destination matches source (bit 0 = A, bit 1 = B) |
| src_is_r31 | input | 2 | Source specifier is register 31 (bit 0 = A, bit 1 = B) |
| alu_makes_result | input | 1 | Stage-2 instruction produces its result in the ALU |
| wb_writes_reg | input | 1 | Stage-3 instruction writes the register file |
| rf_data_a | input | 32 | Register-file read data for source A |
| rf_data_b | input | 32 | Register-file read data for source B |
| alu_result | input | 32 | Result computed in the ALU stage |
| wb_value | input | 32 | Value being written back in stage 3 |
| sel_a | output | 2 | Forwarding select for A (00 file, 01 ALU stage, 10 writeback) |
| sel_b | output | 2 | Forwarding select for B (same encoding) |
| fwd_a | output | 1 | A comes from forwarding, not the register file |
| fwd_b | output | 1 | B comes from forwarding, not the register file |
| opnd_a | output | 32 | Selected value of A |
| opnd_b | output | 32 | Selected value of B |

## Verification
The assertions check every evaluation for the invariants that need no history: register 31 never forwards, a stage-2 match without an ALU result never selects stage 2, the flag agrees with the select, and each data output equals the source its select names. The priority between the two stages and the exact value chosen for each combination can only be shown by the bench's scenarios. These include an exhaustive sweep of all control combinations with distinct data words on every source, and cases that change one operand's inputs while the other's are held.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_ALU = 2'b01,
    SRC_WB  = 2'b10
  } src_sel_e;

  // Priority: r31 never forwards; a stage-2 hit owns the source (forward
  // only if ALU-class); otherwise a writing stage-3 hit forwards.
  function automatic src_sel_e pick_source(
    input logic hit_s2,
    input logic hit_s3,
    input logic is_r31,
    input logic s2_alu,
    input logic s3_writes
  );
    src_sel_e r;
    r = SRC_RF;
    if (!is_r31) begin
      if (hit_s2) begin
        if (s2_alu) r = SRC_ALU;
      end else if (hit_s3 && s3_writes) begin
        r = SRC_WB;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/opfwd_select.sv
module opfwd_select
  import opfwd_pkg::*;
(
  input  logic       hit_s2,
  input  logic       hit_s3,
  input  logic       is_r31,
  input  logic       s2_alu,
  input  logic       s3_writes,
  output logic [1:0] sel,
  output logic       bypassed,
  output logic       load_blocked
);

  src_sel_e choice;

  always_comb begin
    choice   = pick_source(hit_s2, hit_s3, is_r31, s2_alu, s3_writes);
    sel      = choice;
    bypassed = (choice != SRC_RF);
  end

  // Named event: a stage-2 producer owns this source but cannot forward yet.
  assign load_blocked = hit_s2 && !s2_alu && !is_r31;

  always_comb begin
    a_r5_load_not_forwarded: assert (!(load_blocked && bypassed))
      else $error("R5: source forwarded past a stage-2 load");
  end

endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] alu_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] out_val
);

  always_comb begin
    unique case (sel)
      2'b01:   out_val = alu_val;
      2'b10:   out_val = wb_val;
      default: out_val = rf_val;
    endcase
  end

endmodule

// File: rtl/opfwd_bypass_unit.sv
module opfwd_bypass_unit #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        hit_alu,
  input  logic [1:0]        hit_wb,
  input  logic [1:0]        src_is_r31,
  input  logic              alu_makes_result,
  input  logic              wb_writes_reg,
  input  logic [DATA_W-1:0] rf_data_a,
  input  logic [DATA_W-1:0] rf_data_b,
  input  logic [DATA_W-1:0] alu_result,
  input  logic [DATA_W-1:0] wb_value,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              fwd_a,
  output logic              fwd_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int NUM_SRC = 2;

  logic [DATA_W-1:0] rf_vec   [NUM_SRC];
  logic [DATA_W-1:0] opnd_vec [NUM_SRC];
  logic [1:0]        sel_vec  [NUM_SRC];
  logic [NUM_SRC-1:0] fwd_vec;
  logic [NUM_SRC-1:0] load_blocked_vec;

  assign rf_vec[0] = rf_data_a;
  assign rf_vec[1] = rf_data_b;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    opfwd_select u_sel (
      .hit_s2      (hit_alu[i]),
      .hit_s3      (hit_wb[i]),
      .is_r31      (src_is_r31[i]),
      .s2_alu      (alu_makes_result),
      .s3_writes   (wb_writes_reg),
      .sel         (sel_vec[i]),
      .bypassed    (fwd_vec[i]),
      .load_blocked(load_blocked_vec[i])
    );

    opfwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel    (sel_vec[i]),
      .rf_val (rf_vec[i]),
      .alu_val(alu_result),
      .wb_val (wb_value),
      .out_val(opnd_vec[i])
    );

    always_comb begin
      a_r1_r31_never_forwarded: assert (!(src_is_r31[i] && fwd_vec[i]))
        else $error("R1: register 31 forwarded");
      a_r7_flag_agrees_select: assert ((sel_vec[i] != 2'b00) == fwd_vec[i] && sel_vec[i] != 2'b11)
        else $error("R7: flag/select mismatch");
      a_r2_alu_data_routed: assert (!(sel_vec[i] == 2'b01) || (opnd_vec[i] == alu_result && hit_alu[i] && alu_makes_result))
        else $error("R2: stage-2 path inconsistent");
      a_r3_wb_data_routed: assert (!(sel_vec[i] == 2'b10) || (opnd_vec[i] == wb_value && hit_wb[i] && wb_writes_reg && !hit_alu[i]))
        else $error("R3: stage-3 path inconsistent");
      a_r6_rf_data_routed: assert (fwd_vec[i] || opnd_vec[i] == rf_vec[i])
        else $error("R6: unforwarded operand differs from register file");
    end
  end

  assign sel_a  = sel_vec[0];
  assign sel_b  = sel_vec[1];
  assign fwd_a  = fwd_vec[0];
  assign fwd_b  = fwd_vec[1];
  assign opnd_a = opnd_vec[0];
  assign opnd_b = opnd_vec[1];

endmodule

// File: tb/opfwd_bypass_unit_bench.sv
module opfwd_bypass_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  typedef struct {
    string      tag;
    logic [1:0] sel_a, sel_b;
    logic       fwd_a, fwd_b;
    logic [DW-1:0] opnd_a, opnd_b;
  } exp_t;

  logic clk = 1'b0;
  logic [1:0] hit_alu = '0, hit_wb = '0, src_is_r31 = '0;
  logic alu_makes_result = 1'b0, wb_writes_reg = 1'b0;
  logic [DW-1:0] rf_data_a = '0, rf_data_b = '0, alu_result = '0, wb_value = '0;
  logic [1:0] sel_a, sel_b;
  logic fwd_a, fwd_b;
  logic [DW-1:0] opnd_a, opnd_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  opfwd_bypass_unit #(.DATA_W(DW)) u_opfwd_bypass_unit (
    .hit_alu(hit_alu), .hit_wb(hit_wb), .src_is_r31(src_is_r31),
    .alu_makes_result(alu_makes_result), .wb_writes_reg(wb_writes_reg),
    .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
    .alu_result(alu_result), .wb_value(wb_value),
    .sel_a(sel_a), .sel_b(sel_b), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // Independent model written as a lookup over priorities.
  function automatic logic [1:0] model_sel(logic h2, logic h3, logic r31, logic alu, logic wr);
    if (r31) return 2'b00;
    if (h2 && alu) return 2'b01;
    if (h2) return 2'b00;
    if (h3 && wr) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] model_data(logic [1:0] s, logic [DW-1:0] rf);
    return (s == 2'b01) ? alu_result : (s == 2'b10) ? wb_value : rf;
  endfunction

  task automatic drive(string tag, logic [1:0] h2, logic [1:0] h3, logic [1:0] r31,
                       logic alu, logic wr);
    exp_t e;
    @(posedge clk);
    #1;
    hit_alu = h2; hit_wb = h3; src_is_r31 = r31;
    alu_makes_result = alu; wb_writes_reg = wr;
    e.tag    = tag;
    e.sel_a  = model_sel(h2[0], h3[0], r31[0], alu, wr);
    e.sel_b  = model_sel(h2[1], h3[1], r31[1], alu, wr);
    e.fwd_a  = (e.sel_a != 2'b00);
    e.fwd_b  = (e.sel_b != 2'b00);
    e.opnd_a = model_data(e.sel_a, rf_data_a);
    e.opnd_b = model_data(e.sel_b, rf_data_b);
    q.push_back(e);
  endtask

  task automatic cmp(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare mid-cycle, after inputs settled.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "sel_a", {30'd0, sel_a}, {30'd0, e.sel_a});
        cmp(e.tag, "sel_b", {30'd0, sel_b}, {30'd0, e.sel_b});
        cmp(e.tag, "fwd_a", {31'd0, fwd_a}, {31'd0, e.fwd_a});
        cmp(e.tag, "fwd_b", {31'd0, fwd_b}, {31'd0, e.fwd_b});
        cmp(e.tag, "opnd_a", opnd_a, e.opnd_a);
        cmp(e.tag, "opnd_b", opnd_b, e.opnd_b);
      end
    end
  end

  initial begin
    rf_data_a = 32'hAAAA_0001; rf_data_b = 32'hBBBB_0002;
    alu_result = 32'hC0DE_0003; wb_value = 32'hD00D_0004;
    // Idle state: nothing matches (R6)
    drive("R6", 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
    // R2: stage-2 ALU hit on A only, then B only
    drive("R2", 2'b01, 2'b00, 2'b00, 1'b1, 1'b0);
    drive("R2", 2'b10, 2'b00, 2'b00, 1'b1, 1'b1);
    // R3: stage-3 writer hits both
    drive("R3", 2'b00, 2'b11, 2'b00, 1'b0, 1'b1);
    // R4: both stages hit, ALU result wins
    drive("R4", 2'b11, 2'b11, 2'b00, 1'b1, 1'b1);
    // R5: load in stage 2 blocks stage-3 forwarding
    drive("R5", 2'b11, 2'b11, 2'b00, 1'b0, 1'b1);
    drive("R5", 2'b01, 2'b00, 2'b00, 1'b0, 1'b0);
    // R6: stage-3 hit but no register write
    drive("R6", 2'b00, 2'b11, 2'b00, 1'b1, 1'b0);
    // R1: register 31 with every match active
    drive("R1", 2'b11, 2'b11, 2'b11, 1'b1, 1'b1);
    drive("R1", 2'b11, 2'b11, 2'b01, 1'b1, 1'b1);
    // R8: A changes, B held on a stage-3 forward
    drive("R8", 2'b01, 2'b10, 2'b00, 1'b1, 1'b1);
    drive("R8", 2'b00, 2'b10, 2'b01, 1'b1, 1'b1);
    // R7 and R8: exhaustive control sweep with new data words
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      @(posedge clk);
      rf_data_a  = 32'h1000_0000 + v;
      rf_data_b  = 32'h2000_0000 + v;
      alu_result = 32'h3000_0000 + v;
      wb_value   = 32'h4000_0000 + v;
      drive("R7", b[1:0], b[3:2], b[5:4], b[6], b[7]);
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule